// File: doc/BRIEF.md
# Supply Supervisor Reset Sequencer

This block is the digital sequencer behind an analog supply monitor. It takes two comparator decisions: the supply is above the reset threshold, and the supply is above a higher early-warning threshold. From them it produces a held system reset, a power-on flag, an early-warning (power-fail) flag and a maskable power-fail interrupt request. Both comparator bits pass through two-flop synchronizers before any logic uses them.

System reset is held the whole time the supply is below the reset threshold. It is released only after the supply has stayed good for a stabilisation count of `HOLD_CYCLES` clocks (65,536 by default). A dip during that count sends the counter back to zero, and a dip after release starts the whole power-on sequence again.

The power-on flag is raised by every reset sequence. The power-fail flag is raised whenever the supply is below the early-warning threshold, whatever the interrupt enable holds. Software removes either flag only with a clear pulse, and a set that lands in the same cycle as a clear wins. The interrupt request is the power-fail flag gated by its enable.

Top module: `supply_supervisor`

## Requirements
- R1: `sys_rst_out` is 1 (reset asserted, actively driven high) for as long as the synchronized `supply_ok_in` is 0.
- R2: When `supply_ok_in` rises and stays high, `sys_rst_out` is still 1 after the (HOLD_CYCLES+1)th rising edge and becomes 0 on the (HOLD_CYCLES+2)th rising edge: two synchronizer stages plus a HOLD_CYCLES-clock count.
- R3: A drop of `supply_ok_in` during the count returns the counter to zero. After the supply returns, a complete HOLD_CYCLES+2 edge sequence is needed again, and no partial count carries over.
- R4: A drop of `supply_ok_in` after release drives `sys_rst_out` back to 1 by the third rising edge after the drop, and sets `por_flag`.
- R5: `por_flag` is 1 whenever reset is held. Once reset is released it stays 1 until a `por_flag_clr` pulse, and that pulse clears it on the next edge.
- R6: `pf_flag` is set while the synchronized `warn_ok_in` is 0, whatever the value of `pf_irq_en`. It stays 1 after `warn_ok_in` returns high until a `pf_flag_clr` pulse clears it.
- R7: `pf_irq` is 1 exactly when `pf_irq_en` is 1 and `pf_flag` is 1.
- R8: If a clear pulse and a set condition for the same flag fall in the same cycle, the flag stays 1. For `pf_flag` the set condition is a low synchronized `warn_ok_in`. For `por_flag` it is reset being held.
- R9: While `rst` is high at a clock edge, the block returns to `sys_rst_out`=1, `por_flag`=1, `pf_flag`=0 and `pf_irq`=0, with the counter at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-up reset |
| supply_ok_in | input | 1 | Comparator: supply above reset threshold (asynchronous) |
| warn_ok_in | input | 1 | Comparator: supply above early-warning threshold (asynchronous) |
| pf_irq_en | input | 1 | Power-fail interrupt enable |
| por_flag_clr | input | 1 | One-cycle pulse that clears the power-on flag |
| pf_flag_clr | input | 1 | One-cycle pulse that clears the power-fail flag |
| sys_rst_out | output | 1 | System reset, 1 = held in reset |
| por_flag | output | 1 | Power-on reset flag |
| pf_flag | output | 1 | Power-fail (early-warning) flag |
| pf_irq | output | 1 | Power-fail interrupt request |

## Verification
The clear pulse from software and the set condition from the comparators can hit the same flag in one cycle. For the power-fail flag, the bench holds `warn_ok_in` low until the synchronized value is low and then pulses `pf_flag_clr`. For the power-on flag, it pulses `por_flag_clr` while reset is still held. In both cases the flag must read 1 on the edge after the pulse. The reverse case is also checked: a clear arriving after the warning input has recovered must take the flag to 0, so that the set-wins rule is seen to be a priority and not a stuck flag.

// File: rtl/supsv_pkg.sv
package supsv_pkg;

    localparam int unsigned DEF_HOLD_CYCLES = 65536;
    localparam int unsigned DEF_SYNC_STAGES = 2;

    typedef enum logic {
        PH_HOLD = 1'b0,
        PH_RUN  = 1'b1
    } phase_e;

    typedef struct packed {
        logic supply_ok;
        logic warn_ok;
    } cmp_t;

    typedef struct packed {
        logic set;
        logic clr;
    } flag_req_t;

    function automatic logic next_flag(input logic cur, input flag_req_t req);
        if (req.set)
            return 1'b1;
        else if (req.clr)
            return 1'b0;
        else
            return cur;
    endfunction

endpackage

// File: rtl/supsv_sync.sv
module supsv_sync #(
    parameter int unsigned WIDTH  = 2,
    parameter int unsigned STAGES = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] stg [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stg[g] <= RST_VAL;
                else     stg[g] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stg[g] <= RST_VAL;
                else     stg[g] <= stg[g-1];
            end
        end
    end

    assign q = stg[STAGES-1];

endmodule

// File: rtl/supsv_rst_seq.sv
module supsv_rst_seq #(
    parameter int unsigned HOLD_CYCLES = supsv_pkg::DEF_HOLD_CYCLES
) (
    input  logic clk,
    input  logic rst,
    input  logic ok_sync,
    output logic rst_hold
);
    import supsv_pkg::*;

    localparam int unsigned CNT_W = (HOLD_CYCLES > 2) ? $clog2(HOLD_CYCLES) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(HOLD_CYCLES - 1);

    phase_e           phase;
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_HOLD;
            cnt   <= '0;
        end else if (!ok_sync) begin
            phase <= PH_HOLD;
            cnt   <= '0;
        end else if (phase == PH_HOLD) begin
            if (cnt == LAST) begin
                phase <= PH_RUN;
                cnt   <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    assign rst_hold = (phase == PH_HOLD);

    AST_HOLD_WHILE_LOW: assert property (@(posedge clk) disable iff (rst)
        !ok_sync |=> rst_hold); // R1

    AST_DIP_CLEARS_COUNT: assert property (@(posedge clk) disable iff (rst)
        !ok_sync |=> (cnt == '0)); // R3

    AST_RELEASE_AT_LAST: assert property (@(posedge clk) disable iff (rst)
        $fell(rst_hold) |-> ($past(cnt) == LAST)); // R2

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        cnt <= LAST); // R2

endmodule

// File: rtl/supsv_flags.sv
module supsv_flags (
    input  logic clk,
    input  logic rst,
    input  logic rst_hold,
    input  logic warn_sync,
    input  logic pf_en,
    input  logic por_clr,
    input  logic pf_clr,
    output logic por_flag,
    output logic pf_flag,
    output logic pf_irq
);
    import supsv_pkg::*;

    flag_req_t por_req;
    flag_req_t pf_req;

    always_comb begin
        por_req.set = rst_hold;
        por_req.clr = por_clr;
        pf_req.set  = !warn_sync;
        pf_req.clr  = pf_clr;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            por_flag <= 1'b1;
            pf_flag  <= 1'b0;
        end else begin
            por_flag <= next_flag(por_flag, por_req);
            pf_flag  <= next_flag(pf_flag, pf_req);
        end
    end

    assign pf_irq = pf_en & pf_flag;

    AST_POR_SET_IN_HOLD: assert property (@(posedge clk) disable iff (rst)
        rst_hold |=> por_flag); // R5

    AST_PF_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        (!warn_sync && pf_clr) |=> pf_flag); // R8

    AST_PF_STICKY: assert property (@(posedge clk) disable iff (rst)
        (pf_flag && !pf_clr) |=> pf_flag); // R6

    AST_POR_STICKY: assert property (@(posedge clk) disable iff (rst)
        (por_flag && !por_clr) |=> por_flag); // R5

endmodule

// File: rtl/supply_supervisor.sv
module supply_supervisor #(
    parameter int unsigned HOLD_CYCLES = supsv_pkg::DEF_HOLD_CYCLES,
    parameter int unsigned SYNC_STAGES = supsv_pkg::DEF_SYNC_STAGES
) (
    input  logic clk,
    input  logic rst,
    input  logic supply_ok_in,
    input  logic warn_ok_in,
    input  logic pf_irq_en,
    input  logic por_flag_clr,
    input  logic pf_flag_clr,
    output logic sys_rst_out,
    output logic por_flag,
    output logic pf_flag,
    output logic pf_irq
);
    import supsv_pkg::*;

    cmp_t cmp_raw;
    cmp_t cmp_sync;
    logic rst_hold;

    assign cmp_raw.supply_ok = supply_ok_in;
    assign cmp_raw.warn_ok   = warn_ok_in;

    // Supply-OK resets to 0 (held), warning resets to 1 (no spurious flag).
    supsv_sync #(
        .WIDTH   ($bits(cmp_t)),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (2'b01)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (cmp_raw),
        .q   (cmp_sync)
    );

    supsv_rst_seq #(
        .HOLD_CYCLES (HOLD_CYCLES)
    ) u_seq (
        .clk      (clk),
        .rst      (rst),
        .ok_sync  (cmp_sync.supply_ok),
        .rst_hold (rst_hold)
    );

    supsv_flags u_flags (
        .clk       (clk),
        .rst       (rst),
        .rst_hold  (rst_hold),
        .warn_sync (cmp_sync.warn_ok),
        .pf_en     (pf_irq_en),
        .por_clr   (por_flag_clr),
        .pf_clr    (pf_flag_clr),
        .por_flag  (por_flag),
        .pf_flag   (pf_flag),
        .pf_irq    (pf_irq)
    );

    assign sys_rst_out = rst_hold;

endmodule

// File: tb/supply_supervisor_tb.sv
`timescale 1ns/1ps
module supply_supervisor_tb;

    localparam int unsigned HOLD = 65536;

    logic clk = 1'b0;
    logic rst;
    logic supply_ok_in, warn_ok_in, pf_irq_en, por_flag_clr, pf_flag_clr;
    logic sys_rst_out, por_flag, pf_flag, pf_irq;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    supply_supervisor #(.HOLD_CYCLES(HOLD)) u_dut (
        .clk          (clk),
        .rst          (rst),
        .supply_ok_in (supply_ok_in),
        .warn_ok_in   (warn_ok_in),
        .pf_irq_en    (pf_irq_en),
        .por_flag_clr (por_flag_clr),
        .pf_flag_clr  (pf_flag_clr),
        .sys_rst_out  (sys_rst_out),
        .por_flag     (por_flag),
        .pf_flag      (pf_flag),
        .pf_irq       (pf_irq)
    );

    // Vector fields: {warn_ok_in, pf_irq_en, pf_flag_clr, exp_pf_flag, exp_pf_irq}
    localparam logic [4:0] VEC [9] = '{
        5'b10000,  // R6: no warning, flag stays 0
        5'b00010,  // R6: warning sets flag with enable off
        5'b10010,  // R6: flag sticky after warning lifts
        5'b11011,  // R7: enable on -> irq
        5'b11100,  // R6/R7: clear removes flag and irq
        5'b01111,  // R8: clear with warning low, set wins
        5'b11100,  // R8: clear after warning lifts
        5'b00010,  // R7: flag set, enable off, no irq
        5'b10100   // R6: clear again
    };

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (180000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1;
        supply_ok_in = 1'b0;
        warn_ok_in   = 1'b1;
        pf_irq_en    = 1'b1;
        por_flag_clr = 1'b0;
        pf_flag_clr  = 1'b0;
        edges(3);
        check("R9 sys_rst_out", sys_rst_out, 1'b1);
        check("R9 por_flag", por_flag, 1'b1);
        check("R9 pf_flag", pf_flag, 1'b0);
        check("R9 pf_irq", pf_irq, 1'b0);
        @(negedge clk) rst = 1'b0;

        // Vector table for the power-fail flag and interrupt (supply still low).
        for (int i = 0; i < 9; i++) begin
            @(negedge clk);
            warn_ok_in = VEC[i][4];
            pf_irq_en  = VEC[i][3];
            edges(3);
            @(negedge clk) pf_flag_clr = VEC[i][2];
            edges(1);
            @(negedge clk) pf_flag_clr = 1'b0;
            check($sformatf("R6/R7/R8 vec%0d pf_flag", i), pf_flag, VEC[i][1]);
            check($sformatf("R7 vec%0d pf_irq", i), pf_irq, VEC[i][0]);
        end

        check("R1 held while supply low", sys_rst_out, 1'b1);

        // R8: clear of por_flag while reset held
        @(negedge clk) por_flag_clr = 1'b1;
        edges(1);
        @(negedge clk) por_flag_clr = 1'b0;
        check("R8 por_flag set wins in hold", por_flag, 1'b1);

        // R2: full release timing
        @(negedge clk) supply_ok_in = 1'b1;
        edges(100);
        check("R1 held during count", sys_rst_out, 1'b1);
        edges(HOLD + 1 - 100);
        check("R2 still held at HOLD+1", sys_rst_out, 1'b1);
        edges(1);
        check("R2 released at HOLD+2", sys_rst_out, 1'b0);

        // R5: flag persists after release, then clears
        edges(5);
        check("R5 por_flag kept after release", por_flag, 1'b1);
        @(negedge clk) por_flag_clr = 1'b1;
        edges(1);
        @(negedge clk) por_flag_clr = 1'b0;
        check("R5 por_flag cleared", por_flag, 1'b0);
        edges(3);
        check("R5 por_flag stays cleared", por_flag, 1'b0);

        // R4: dip after release
        @(negedge clk) supply_ok_in = 1'b0;
        edges(2);
        check("R4 not yet asserted at edge 2", sys_rst_out, 1'b0);
        edges(1);
        check("R4 reasserted by edge 3", sys_rst_out, 1'b1);
        edges(1);
        check("R4 por_flag set", por_flag, 1'b1);

        // R3: partial count, dip, then full count again
        @(negedge clk) supply_ok_in = 1'b1;
        edges(1000);
        check("R3 held mid-count", sys_rst_out, 1'b1);
        @(negedge clk) supply_ok_in = 1'b0;
        edges(4);
        @(negedge clk) supply_ok_in = 1'b1;
        edges(HOLD + 1);
        check("R3 still held at HOLD+1 after dip", sys_rst_out, 1'b1);
        edges(1);
        check("R3 released at HOLD+2 after dip", sys_rst_out, 1'b0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule